// File: doc/BRIEF.md
# Noise-Shaping Fraction Modulator

This block turns a constant fraction word into a stream of small signed integer offsets. Add each offset to an integer divide ratio and the long-run average ratio becomes that integer plus frac / 2^W. The quantization error of the stream is shaped toward high frequencies by (1 - z^-1)^ORDER.

The block cascades up to three wrap-around accumulators. The first stage adds the fraction word. Each later stage adds the sum that the stage before it has just produced. The carry of each later stage is differenced before it is added to the output, once for the second stage and twice for the third.

The stages advance only on a strobe that comes once per reference period. The offset is registered, so it appears just after the clock edge that took the strobe. ORDER chooses one, two or three stages; two is the default.

Top module: `frac_shaper`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears every accumulator and every carry delay register, and sets offset to 0.
- R2: While step is low, no state changes and offset holds its value.
- R3: On each clock edge where step is high, stage 1 takes acc1 + frac modulo 2^W. Its carry c1 is bit W of the unwrapped sum.
- R4: With ORDER=2, stage 2 adds the new stage-1 sum modulo 2^W and gives carry c2. Offset becomes c1(n) + c2(n) - c2(n-1) on the same edge. c2(n-1) is the stage-2 carry of the previous strobe, or 0 after reset.
- R5: With ORDER=2, offset is a 3-bit two's complement value and always lies in the range -1 to +2.
- R6: Over N strobes from reset with a constant frac, the sum of the offsets stays within 2 of N*frac/2^W, for each of ORDER 1, 2 and 3.
- R7: With ORDER=1, offset is the stage-1 carry alone. For frac=16'h4000, the offsets from reset run 0,0,0,1 and then repeat.
- R8: With ORDER=2 and frac=16'h4000, the offset sequence is dithered. Within the first 16 strobes it differs from the ORDER=1 sequence in at least one position; at the third strobe the outputs are 1 and 0.
- R9: With ORDER=3, stage 3 adds the new stage-2 sum and gives carry c3. Offset becomes c1 + c2(n) - c2(n-1) + c3(n) - 2*c3(n-1) + c3(n-2), held as a 4-bit signed value in the range -3 to +4.
- R10: A new frac value takes effect at the next strobe and does not clear the accumulated state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Advance strobe, one per reference period |
| frac | input | W | Fraction word, value frac/2^W |
| offset | output | ORDER+1 | Signed divide-ratio offset |

## Verification
A quarter-scale fraction word from reset separates the plain periodic carry from the dithered two-stage output. It also confirms the exact 0,0,0,1 pattern of the single stage. A mid-run change of the word to an irregular value, with the state left in place, shows that the new input takes effect at once. A pause in the strobe shows that the output holds. A long run with a third word, compared against bench models of the two- and three-stage cascades, checks the cycle-exact values, the range of each order and the long-run mean.

// File: rtl/frac_shaper.sv
module frac_shaper #(
  parameter int W = 16,
  parameter int ORDER = 2,
  localparam int OW = ORDER + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic [W-1:0]         frac,
  output logic signed [OW-1:0] offset
);

  logic [W-1:0] acc [ORDER];
  logic [W:0]   sum [ORDER];
  logic [2:0]   cy;
  logic         d2, d3a, d3b;
  logic [OW-1:0] y;
  logic         idle;

  always_comb begin
    logic [W-1:0] feed;
    feed = frac;
    cy = '0;
    idle = !d2 && !d3a && !d3b;
    for (int g = 0; g < ORDER; g++) begin
      sum[g] = {1'b0, acc[g]} + {1'b0, feed};
      cy[g]  = sum[g][W];
      feed   = sum[g][W-1:0];
      idle   = idle && (acc[g] == '0);
    end
  end

  always_comb begin
    y = OW'(cy[0]);
    if (ORDER >= 2) y = y + OW'(cy[1]) - OW'(d2);
    if (ORDER >= 3) y = y + OW'(cy[2]) - OW'({d3a, 1'b0}) + OW'(d3b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < ORDER; g++) acc[g] <= '0;
      d2 <= 1'b0;
      d3a <= 1'b0;
      d3b <= 1'b0;
      offset <= '0;
    end else if (step) begin
      for (int g = 0; g < ORDER; g++) acc[g] <= sum[g][W-1:0];
      d2 <= cy[1];
      d3a <= cy[2];
      d3b <= d3a;
      offset <= y;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> offset == '0);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(offset));

  // R5
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offset >= -((2 ** (ORDER - 1)) - 1)) && (offset <= (2 ** (ORDER - 1))));

  // R3
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && idle && frac == '0) |=> offset == '0);

endmodule

// File: tb/tb_frac_shaper.sv
`timescale 1ns/1ps
module tb_frac_shaper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic [15:0] frac = '0;
  logic signed [2:0] offset;
  logic signed [1:0] off1;
  logic signed [3:0] off3;

  int checks = 0;
  int errors = 0;

  frac_shaper #(.W(16), .ORDER(2)) dut (.clk(clk), .rst_n(rst_n), .step(step), .frac(frac), .offset(offset));
  frac_shaper #(.W(16), .ORDER(1)) u_o1 (.clk(clk), .rst_n(rst_n), .step(step), .frac(frac), .offset(off1));
  frac_shaper #(.W(16), .ORDER(3)) u_o3 (.clk(clk), .rst_n(rst_n), .step(step), .frac(frac), .offset(off3));

  always #2.5 clk = ~clk;

  int q2[$];
  int q3[$];
  int h1[$];
  int h2[$];
  longint s1, s2, s3;
  int bad_rng2, bad_rng3;
  logic [15:0] m1, m2, m3;
  int p2, p3a, p3b;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    step = 1'b0;
    rst_n = 1'b0;
    m1 = 0; m2 = 0; m3 = 0; p2 = 0; p3a = 0; p3b = 0;
    q2.delete(); q3.delete(); h1.delete(); h2.delete();
    s1 = 0; s2 = 0; s3 = 0; bad_rng2 = 0; bad_rng3 = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic strobe(input logic [15:0] f);
    logic [16:0] a, b, c;
    int c1, c2, c3;
    @(negedge clk);
    frac = f;
    step = 1'b1;
    a = {1'b0, m1} + {1'b0, f};
    c1 = int'(a[16]); m1 = a[15:0];
    b = {1'b0, m2} + {1'b0, m1};
    c2 = int'(b[16]); m2 = b[15:0];
    c = {1'b0, m3} + {1'b0, m2};
    c3 = int'(c[16]); m3 = c[15:0];
    q2.push_back(c1 + c2 - p2);
    q3.push_back(c1 + c2 - p2 + c3 - 2 * p3a + p3b);
    p2 = c2; p3b = p3a; p3a = c3;
  endtask

  task automatic pause(input int n);
    int held;
    @(negedge clk);
    step = 1'b0;
    held = int'(offset);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R2 hold", int'(offset), held);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && step) begin
      int e2, e3;
      #1;
      e2 = q2.pop_front();
      e3 = q3.pop_front();
      check("R4 order2 value", int'(offset), e2);
      check("R9 order3 value", int'(off3), e3);
      h1.push_back(int'(off1));
      h2.push_back(int'(offset));
      s1 += longint'(off1); s2 += longint'(offset); s3 += longint'(off3);
      if (offset < -1 || offset > 2) bad_rng2++;
      if (off3 < -3 || off3 > 4) bad_rng3++;
    end
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int diffs;
    longint d;
    do_reset();
    @(negedge clk);
    check("R1 reset order2", int'(offset), 0);
    check("R1 reset order1", int'(off1), 0);
    check("R1 reset order3", int'(off3), 0);

    for (int i = 0; i < 16; i++) strobe(16'h4000);
    pause(6);
    for (int i = 0; i < 16; i++) check("R7 order1 pattern", h1[i], (i % 4 == 3) ? 1 : 0);
    check("R8 third strobe order2", h2[2], 1);
    check("R8 third strobe order1", h1[2], 0);
    diffs = 0;
    for (int i = 0; i < 16; i++) if (h1[i] != h2[i]) diffs++;
    check("R8 dithered differs", int'(diffs > 0), 1);

    for (int i = 0; i < 200; i++) strobe(16'h5A3C);
    pause(4);
    check("R10 scoreboard drained", q2.size(), 0);

    do_reset();
    for (int i = 0; i < 4096; i++) strobe(16'h2B7F);
    pause(3);
    d = s1 * 65536 - 4096 * longint'(16'h2B7F);
    check("R6 mean order1", int'(d <= 2 * 65536 && d >= -2 * 65536), 1);
    d = s2 * 65536 - 4096 * longint'(16'h2B7F);
    check("R6 mean order2", int'(d <= 2 * 65536 && d >= -2 * 65536), 1);
    d = s3 * 65536 - 4096 * longint'(16'h2B7F);
    check("R6 mean order3", int'(d <= 2 * 65536 && d >= -2 * 65536), 1);
    check("R5 order2 range", bad_rng2, 0);
    check("R9 order3 range", bad_rng3, 0);
    check("R3 scoreboard drained", q2.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule